// File: doc/BRIEF.md
# Clock Mode Control Register

This block holds the 8-bit control register through which a processor chooses how an on-chip clock generator runs. The register has three fields. A 2-bit mode field picks self-clocked operation, a frequency-locked loop on the internal reference, the external reference with the loop bypassed, or a frequency-locked loop on the external reference. A range bit picks a high or low external frequency range. A source bit picks a crystal or resonator, or a driven external clock. Software writes and reads the whole register through a plain register port. The block then drives the committed settings to the generator.

The block enforces the rules that keep software from putting the generator into an unsafe state. The range and source bits accept only the first write after reset. If that first write selects a mode whose upper bit is 0, the two external modes stay barred until the next reset. A mode write is refused while an earlier change has not been acknowledged. The bypassed external mode is held back until the generator reports a stable external reference.

Top module: `clkmode_ctrl`

## Requirements
- R1: After synchronous reset, `rd_data` reads 0x08 (range bit 1, source bit 0, mode 00), `mode_out` is 00 and `mode_pending` is 0.
- R2: The range bit sits at bit 3. Only the first write after reset sets it, and later writes leave it unchanged.
- R3: The source bit (1 = crystal or resonator, 0 = driven clock) sits at bit 2 and appears on `xtal_sel`. Only the first write after reset sets it.
- R4: The mode field sits at bits 1:0, with 00 = self-clocked, 01 = loop on internal reference, 10 = external reference with loop bypassed, and 11 = loop on external reference. If the first write after reset carries a mode with bit 1 = 0, any later mode write with bit 1 = 1 is refused until reset. Writes with bit 1 = 0 are still accepted.
- R5: An accepted mode of 10 reaches `mode_out` only in a cycle where `ext_ref_ok` is 1. Until then, `mode_out` keeps its previous value.
- R6: A mode write that arrives while `mode_pending` is 1 leaves the mode field unchanged.
- R7: The `gen_off` input changes neither the register contents nor `mode_out`.
- R8: `ext_range_hi` is 1 only when bit 1 of `mode_out` is 1 and the range bit is 1. `ext_pre64` (low range, prescale 64) is 1 only when bit 1 of `mode_out` is 1 and the range bit is 0. In the internal modes, both outputs are 0.
- R9: Bits 7:4 always read 0 and ignore writes.
- R10: An accepted mode write sets `mode_pending`. It clears only in a cycle where `mode_done` is 1 and the written mode is already on `mode_out`.
- R11: When the gate is open, an accepted mode appears on `mode_out` one cycle after the write is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register contents |
| ext_ref_ok | input | 1 | External reference is stable |
| mode_done | input | 1 | Generator finished the last mode change |
| gen_off | input | 1 | Generator has entered its off state |
| mode_out | output | 2 | Mode applied to the generator |
| xtal_sel | output | 1 | External source select |
| ext_range_hi | output | 1 | High range in effect |
| ext_pre64 | output | 1 | Low range, prescale 64, in effect |
| mode_pending | output | 1 | Mode change awaiting acknowledgment |

## Verification
The assertions check several properties on every cycle:
- once a write-once bit has been written, it stays unchanged;
- the mode field never holds an upper-1 value while the lock is set;
- mode 10 never reaches `mode_out` without a stable reference in the prior cycle;
- a write during a pending change leaves the mode unchanged;
- the register is quiet in cycles without a write;
- the pending flag falls only after an acknowledgment.

Some behaviours only the bench scenarios can show. These are the exact lock decision for every pair of first and second mode values, with the reference both stable and unstable. They also include the range outputs across all modes, the reset value, and the one-cycle apply latency.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    localparam int REG_W      = 8;
    localparam int MODE_W     = 2;
    localparam int MODE_LSB   = 0;
    localparam int XTAL_BIT   = 2;
    localparam int RANGE_BIT  = 3;
    localparam int ONCE_N     = 2;   // number of write-once bits
    localparam int ONCE_RANGE = 0;   // index of range in once vectors
    localparam int ONCE_XTAL  = 1;   // index of source select

    typedef enum logic [MODE_W-1:0] {
        MODE_SELF       = 2'b00,
        MODE_LOOP_INT   = 2'b01,
        MODE_BYPASS_EXT = 2'b10,
        MODE_LOOP_EXT   = 2'b11
    } cm_mode_e;

    typedef struct packed {
        logic     range_hi;
        logic     xtal;
        cm_mode_e mode;
    } ctl_fields_t;

    localparam logic [ONCE_N-1:0] ONCE_RST = 2'b01; // range=1, xtal=0

    function automatic int once_bit(input int idx);
        return (idx == ONCE_RANGE) ? RANGE_BIT : XTAL_BIT;
    endfunction

    function automatic logic uses_ext(input cm_mode_e m);
        return m[MODE_W-1];
    endfunction

    function automatic logic gate_open(input cm_mode_e m, input logic ref_ok);
        return (m != MODE_BYPASS_EXT) || ref_ok;
    endfunction

    function automatic logic [REG_W-1:0] pack_reg(input ctl_fields_t f);
        logic [REG_W-1:0] r;
        r = '0;
        r[MODE_LSB +: MODE_W] = f.mode;
        r[XTAL_BIT]           = f.xtal;
        r[RANGE_BIT]          = f.range_hi;
        return r;
    endfunction

endpackage

// File: rtl/clkmode_once.sv
module clkmode_once
    import clkmode_pkg::*;
#(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_val,
    output logic q,
    output logic used
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= RST_VAL;
            used <= 1'b0;
        end else if (wr_en && !used) begin
            q    <= wr_val;
            used <= 1'b1;
        end
    end
endmodule

// File: rtl/clkmode_sel.sv
module clkmode_sel
    import clkmode_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  cm_mode_e wr_mode,
    input  logic     ext_ok,
    input  logic     done,
    output cm_mode_e field_q,
    output cm_mode_e applied_q,
    output logic     pending_q,
    output logic     lock_hi_q
);
    logic first_seen;
    logic accept;
    logic refuse_hi;
    logic may_apply;
    logic ack_ok;

    assign refuse_hi = lock_hi_q && uses_ext(wr_mode);
    assign accept    = wr_en && !pending_q && !refuse_hi;
    assign may_apply = pending_q && gate_open(field_q, ext_ok);
    assign ack_ok    = pending_q && done && (applied_q == field_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            first_seen <= 1'b0;
            lock_hi_q  <= 1'b0;
        end else if (wr_en && !first_seen) begin
            first_seen <= 1'b1;
            lock_hi_q  <= !uses_ext(wr_mode);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q   <= MODE_SELF;
            pending_q <= 1'b0;
        end else if (accept) begin
            field_q   <= wr_mode;
            pending_q <= 1'b1;
        end else if (ack_ok) begin
            pending_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            applied_q <= MODE_SELF;
        end else if (may_apply) begin
            applied_q <= field_q;
        end
    end
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
    import clkmode_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ext_ref_ok,
    input  logic             mode_done,
    input  logic             gen_off,
    output logic [MODE_W-1:0] mode_out,
    output logic             xtal_sel,
    output logic             ext_range_hi,
    output logic             ext_pre64,
    output logic             mode_pending
);
    logic [ONCE_N-1:0] once_q;
    logic [ONCE_N-1:0] once_used;
    cm_mode_e          mode_field;
    cm_mode_e          mode_applied;
    logic              mode_lock_hi;
    ctl_fields_t       fields;
    logic              unused_inputs;

    for (genvar i = 0; i < ONCE_N; i++) begin : g_once
        clkmode_once #(
            .RST_VAL (ONCE_RST[i])
        ) once_i (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_en),
            .wr_val (wr_data[once_bit(i)]),
            .q      (once_q[i]),
            .used   (once_used[i])
        );
    end

    clkmode_sel sel_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_mode   (cm_mode_e'(wr_data[MODE_LSB +: MODE_W])),
        .ext_ok    (ext_ref_ok),
        .done      (mode_done),
        .field_q   (mode_field),
        .applied_q (mode_applied),
        .pending_q (mode_pending),
        .lock_hi_q (mode_lock_hi)
    );

    always_comb begin
        fields.range_hi = once_q[ONCE_RANGE];
        fields.xtal     = once_q[ONCE_XTAL];
        fields.mode     = mode_field;
    end

    assign rd_data      = pack_reg(fields);
    assign mode_out     = mode_applied;
    assign xtal_sel     = once_q[ONCE_XTAL];
    assign ext_range_hi = uses_ext(mode_applied) &&  once_q[ONCE_RANGE];
    assign ext_pre64    = uses_ext(mode_applied) && !once_q[ONCE_RANGE];

    assign unused_inputs = gen_off ^ (^wr_data[REG_W-1:RANGE_BIT+1]);
endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] rd_data,
    input logic [1:0] mode_out,
    input logic       ext_ref_ok,
    input logic       mode_done,
    input logic       mode_pending,
    input logic       lock_hi,
    input logic [1:0] once_used,
    input logic [1:0] once_q
);
    a_r2_range_frozen: assert property (@(posedge clk) disable iff (rst)
        once_used[0] |=> $stable(once_q[0]));

    a_r3_xtal_frozen: assert property (@(posedge clk) disable iff (rst)
        once_used[1] |=> $stable(once_q[1]));

    a_r4_lock_keeps_low: assert property (@(posedge clk) disable iff (rst)
        lock_hi |-> !rd_data[1]);

    a_r5_bypass_needs_ref: assert property (@(posedge clk) disable iff (rst)
        (mode_out == 2'b10 && $past(mode_out) != 2'b10) |-> $past(ext_ref_ok));

    a_r6_pending_blocks_write: assert property (@(posedge clk) disable iff (rst)
        (mode_pending && wr_en) |=> $stable(rd_data[1:0]));

    a_r7_quiet_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data));

    a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:4] == 4'h0);

    a_r10_clear_needs_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(mode_pending) |-> $past(mode_done));
endmodule

bind clkmode_ctrl clkmode_ctrl_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .rd_data      (rd_data),
    .mode_out     (mode_out),
    .ext_ref_ok   (ext_ref_ok),
    .mode_done    (mode_done),
    .mode_pending (mode_pending),
    .lock_hi      (mode_lock_hi),
    .once_used    (once_used),
    .once_q       (once_q)
);

// File: tb/clkmode_ctrl_tb_top.sv
module clkmode_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ext_ref_ok = 1'b0;
    logic       mode_done = 1'b0;
    logic       gen_off = 1'b0;
    logic [1:0] mode_out;
    logic       xtal_sel;
    logic       ext_range_hi;
    logic       ext_pre64;
    logic       mode_pending;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done_run = 1'b0;

    always #2 clk = ~clk;

    clkmode_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ext_ref_ok(ext_ref_ok), .mode_done(mode_done),
        .gen_off(gen_off), .mode_out(mode_out), .xtal_sel(xtal_sel),
        .ext_range_hi(ext_range_hi), .ext_pre64(ext_pre64),
        .mode_pending(mode_pending)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); mode_done = 1'b1;
        @(negedge clk); mode_done = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done_run) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 rd", rd_data, 8'h08);
        chk("R1 mode", {6'd0, mode_out}, 8'h00);
        chk("R1 pend", {7'd0, mode_pending}, 8'h00);
        chk("R8 reset internal mode", {6'd0, ext_range_hi, ext_pre64}, 8'h00);

        // R4/R5/R10/R11 sweep: first mode, second mode, reference state
        for (int f = 0; f < 4; f++) begin
            for (int s = 0; s < 4; s++) begin
                for (int e = 0; e < 2; e++) begin
                    logic [1:0] fm, sm, ex;
                    fm = 2'(f); sm = 2'(s);
                    do_reset();
                    ext_ref_ok = e[0];
                    wr({6'd0, fm});
                    chk("R4 first accept", {6'd0, rd_data[1:0]}, {6'd0, fm});
                    chk("R10 pend set", {7'd0, mode_pending}, 8'h01);
                    @(negedge clk);
                    if (fm == 2'b10 && e == 0) begin
                        chk("R5 bypass held", {6'd0, mode_out}, 8'h00);
                        ext_ref_ok = 1'b1;
                        @(negedge clk);
                    end
                    chk("R11 applied", {6'd0, mode_out}, {6'd0, fm});
                    ext_ref_ok = 1'b1;
                    ack();
                    chk("R10 pend clr", {7'd0, mode_pending}, 8'h00);
                    wr({6'd0, sm});
                    ex = (!fm[1] && sm[1]) ? fm : sm;
                    chk("R4 second", {6'd0, rd_data[1:0]}, {6'd0, ex});
                    chk("R4 pend", {7'd0, mode_pending}, {7'd0, ex == sm});
                    @(negedge clk);
                    chk("R11 second applied", {6'd0, mode_out}, {6'd0, ex});
                    ack();
                end
            end
        end

        // R2/R3/R8 write-once sweep
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                logic [1:0] av, bv;
                av = 2'(a); bv = 2'(b);
                do_reset();
                ext_ref_ok = 1'b1;
                wr({4'd0, av, 2'b11});
                @(negedge clk);
                chk("R8 ext hi", {7'd0, ext_range_hi}, {7'd0, av[1]});
                chk("R8 ext pre64", {7'd0, ext_pre64}, {7'd0, !av[1]});
                chk("R3 xtal out", {7'd0, xtal_sel}, {7'd0, av[0]});
                ack();
                wr({4'd0, bv, 2'b01});
                @(negedge clk);
                chk("R2 R3 kept", {6'd0, rd_data[3:2]}, {6'd0, av});
                chk("R8 internal", {6'd0, ext_range_hi, ext_pre64}, 8'h00);
                ack();
            end
        end

        // R6 write during pending, gate closed
        do_reset();
        ext_ref_ok = 1'b0;
        wr(8'h02);
        wr(8'h03);
        chk("R6 ignored", {6'd0, rd_data[1:0]}, 8'h02);
        chk("R5 held", {6'd0, mode_out}, 8'h00);
        ack();
        chk("R10 no clr before apply", {7'd0, mode_pending}, 8'h01);
        ext_ref_ok = 1'b1;
        @(negedge clk);
        chk("R5 released", {6'd0, mode_out}, 8'h02);
        ack();
        wr(8'h01);
        chk("R6 accepted after ack", {6'd0, rd_data[1:0]}, 8'h01);

        // R9 upper bits
        do_reset();
        wr(8'hF7);
        chk("R9 upper", rd_data, 8'h07);

        // R7 off state
        @(negedge clk);
        gen_off = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 rd", rd_data, 8'h07);
        chk("R7 mode", {6'd0, mode_out}, 8'h03);
        gen_off = 1'b0;
        @(negedge clk);
        chk("R7 rd after", rd_data, 8'h07);

        done_run = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule